// File: doc/BRIEF.md
# Pad-Ring Logic-Tree Test Controller

This block puts a device's pad ring into a logic-tree manufacturing test. It chooses among three modes: normal operation, a NAND-tree test and an XNOR-tree test. The choice is made from a 3-bit mode bus and three test-control pins. These pins are sampled on every clock while the synchronous reset is high. The value from the last reset cycle is kept until the next reset.

In either tree mode, the input-buffer values of the pads are chained through one gate per pad. There are two independent chains. Each chain starts from its own seed pad. Chain 1 ends on the interrupt output pad and chain 2 ends on the test-out pad. These two pads are forced to drive. Every other pad output enable is forced off, so the tester alone sets the pad levels. The chains contain no registers, so a seed toggle reaches its chain output with only gate delay.

In normal mode the block is transparent. All pad enables and both shared output pads come straight from the functional logic.

Top module: `tree_test_ctrl`

## Requirements
- R1: When reset is high, a mode bus of 3'b111 with test clock 0, test data 0 and test run 1 selects the NAND tree from the clock edge at which it is sampled.
- R2: When reset is high, a mode bus of 3'b111 with test clock 0, test data 1 and test run 0 selects the XNOR tree.
- R3: Any other combination sampled while reset is high selects normal mode. This covers a mode bus other than 3'b111, a test clock of 1, or test data equal to test run.
- R4: After reset is released, the selected mode does not change, whatever the mode and test pins do, until reset is asserted again.
- R5: In NAND mode, each chain computes s0 = seed and s(i+1) = NAND(s(i), pad[i]) for i from 0 to LEN-1. The irq output carries s(LEN) of chain 1 and tout carries s(LEN) of chain 2.
- R6: In XNOR mode, each chain computes s(i+1) = XNOR(s(i), pad[i]), with the same outputs as R5. Each output therefore equals its seed inverted once for every pad that reads 0.
- R7: Pad index 0 is the stage farthest from the chain output and index LEN-1 is the nearest. In NAND mode, a single 0 at index 0 and a single 0 at index LEN-1 give different outputs when LEN is even.
- R8: In either tree mode, every bit of pad_oe_o is 0, and irq_oe_o and tout_oe_o are both 1.
- R9: In normal mode, pad_oe_o equals func_oe_i, and irq_o, irq_oe_o, tout_o and tout_oe_o equal their functional inputs.
- R10: In tree mode, a change on a seed or chain pad input shows on the chain output without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used only for mode capture |
| rst | input | 1 | Synchronous active-high reset; pins are sampled while it is high |
| test_mode_i | input | 3 | Mode bus; 3'b111 arms tree testing |
| test_clk_i | input | 1 | Test clock pin; must be 0 for tree testing |
| test_din_i | input | 1 | Test data pin; 0 for NAND, 1 for XNOR |
| test_run_i | input | 1 | Test run pin; 1 for NAND, 0 for XNOR |
| seed1_i | input | 1 | Chain 1 input pad |
| seed2_i | input | 1 | Chain 2 input pad |
| chain1_pad_i | input | C1_LEN | Input-buffer values of chain 1 pads; index 0 is farthest from the output |
| chain2_pad_i | input | C2_LEN | Input-buffer values of chain 2 pads; index 0 is farthest from the output |
| func_oe_i | input | NUM_OE | Functional output enables of the ordinary pads |
| func_irq_i | input | 1 | Functional value of the interrupt pad |
| func_irq_oe_i | input | 1 | Functional enable of the interrupt pad |
| func_tout_i | input | 1 | Functional value of the test-out pad |
| func_tout_oe_i | input | 1 | Functional enable of the test-out pad |
| pad_oe_o | output | NUM_OE | Output enables driven to the ordinary pads |
| irq_o | output | 1 | Interrupt pad value; chain 1 result in tree mode |
| irq_oe_o | output | 1 | Interrupt pad enable |
| tout_o | output | 1 | Test-out pad value; chain 2 result in tree mode |
| tout_oe_o | output | 1 | Test-out pad enable |

## Verification
The hardest situation to reach from the ports is showing that the chain order is correct. An XNOR chain gives the same result for any order of its pads, and for many patterns a NAND chain cannot tell the ends of the chain apart either. The stimulus therefore enters NAND mode and walks a single 0 through every position of each chain, comparing each result with a stage-by-stage model. It also checks the two end positions against each other. A second hard case is the hold rule, since the mode pins are inputs the tester can freely move. The bench changes them to every other decoding after reset is released and confirms that both the output behaviour and the enables stay unchanged.

// File: rtl/tree_test_pkg.sv
package tree_test_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_NAND   = 2'b01,
    MODE_XNOR   = 2'b10
  } tree_mode_e;

  localparam logic [2:0] ARM_CODE = 3'b111;

  // Pin decode; anything unlisted falls back to normal operation.
  function automatic tree_mode_e decode_pins(input logic [2:0] mode_bus,
                                             input logic       tclk,
                                             input logic       tdin,
                                             input logic       trun);
    tree_mode_e m;
    m = MODE_NORMAL;
    if (mode_bus == ARM_CODE && !tclk) begin
      if (!tdin && trun)      m = MODE_NAND;
      else if (tdin && !trun) m = MODE_XNOR;
    end
    return m;
  endfunction

endpackage

// File: rtl/tree_mode_latch.sv
module tree_mode_latch
  import tree_test_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_bus_i,
  input  logic       tclk_i,
  input  logic       tdin_i,
  input  logic       trun_i,
  output tree_mode_e mode_o
);

  tree_mode_e mode_q = MODE_NORMAL;

  // Sampled on every reset cycle; the last one before release wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= decode_pins(mode_bus_i, tclk_i, tdin_i, trun_i);
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/tree_chain.sv
module tree_chain #(
  parameter int LEN = 8
) (
  input  logic           nand_sel_i,
  input  logic           seed_i,
  input  logic [LEN-1:0] pad_i,
  output logic           out_o
);

  // One gate per pad; stage 0 sits next to the seed, stage LEN-1 next to the output.
  for (genvar g = 0; g < LEN; g++) begin : g_stage
    logic prev;
    logic s;
    if (g == 0) begin : g_first
      assign prev = seed_i;
    end else begin : g_rest
      assign prev = g_stage[g-1].s;
    end
    assign s = nand_sel_i ? ~(prev & pad_i[g]) : ~(prev ^ pad_i[g]);
  end

  assign out_o = g_stage[LEN-1].s;

endmodule

// File: rtl/tree_pad_ctrl.sv
module tree_pad_ctrl
  import tree_test_pkg::*;
#(
  parameter int NUM_OE = 16
) (
  input  tree_mode_e        mode_i,
  input  logic              chain1_i,
  input  logic              chain2_i,
  input  logic [NUM_OE-1:0] func_oe_i,
  input  logic              func_irq_i,
  input  logic              func_irq_oe_i,
  input  logic              func_tout_i,
  input  logic              func_tout_oe_i,
  output logic [NUM_OE-1:0] pad_oe_o,
  output logic              irq_o,
  output logic              irq_oe_o,
  output logic              tout_o,
  output logic              tout_oe_o
);

  logic in_tree;

  assign in_tree = (mode_i != MODE_NORMAL);

  for (genvar p = 0; p < NUM_OE; p++) begin : g_oe
    assign pad_oe_o[p] = func_oe_i[p] & ~in_tree;
  end

  always_comb begin
    if (in_tree) begin
      irq_o     = chain1_i;
      irq_oe_o  = 1'b1;
      tout_o    = chain2_i;
      tout_oe_o = 1'b1;
    end else begin
      irq_o     = func_irq_i;
      irq_oe_o  = func_irq_oe_i;
      tout_o    = func_tout_i;
      tout_oe_o = func_tout_oe_i;
    end
  end

endmodule

// File: rtl/tree_test_ctrl.sv
module tree_test_ctrl
  import tree_test_pkg::*;
#(
  parameter int C1_LEN = 8,
  parameter int C2_LEN = 6,
  parameter int NUM_OE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        test_mode_i,
  input  logic              test_clk_i,
  input  logic              test_din_i,
  input  logic              test_run_i,
  input  logic              seed1_i,
  input  logic              seed2_i,
  input  logic [C1_LEN-1:0] chain1_pad_i,
  input  logic [C2_LEN-1:0] chain2_pad_i,
  input  logic [NUM_OE-1:0] func_oe_i,
  input  logic              func_irq_i,
  input  logic              func_irq_oe_i,
  input  logic              func_tout_i,
  input  logic              func_tout_oe_i,
  output logic [NUM_OE-1:0] pad_oe_o,
  output logic              irq_o,
  output logic              irq_oe_o,
  output logic              tout_o,
  output logic              tout_oe_o
);

  tree_mode_e mode_q;
  logic       use_nand;
  logic       c1_out;
  logic       c2_out;

  tree_mode_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .mode_bus_i (test_mode_i),
    .tclk_i     (test_clk_i),
    .tdin_i     (test_din_i),
    .trun_i     (test_run_i),
    .mode_o     (mode_q)
  );

  assign use_nand = (mode_q == MODE_NAND);

  tree_chain #(.LEN(C1_LEN)) u_chain1 (
    .nand_sel_i (use_nand),
    .seed_i     (seed1_i),
    .pad_i      (chain1_pad_i),
    .out_o      (c1_out)
  );

  tree_chain #(.LEN(C2_LEN)) u_chain2 (
    .nand_sel_i (use_nand),
    .seed_i     (seed2_i),
    .pad_i      (chain2_pad_i),
    .out_o      (c2_out)
  );

  tree_pad_ctrl #(.NUM_OE(NUM_OE)) u_pads (
    .mode_i         (mode_q),
    .chain1_i       (c1_out),
    .chain2_i       (c2_out),
    .func_oe_i      (func_oe_i),
    .func_irq_i     (func_irq_i),
    .func_irq_oe_i  (func_irq_oe_i),
    .func_tout_i    (func_tout_i),
    .func_tout_oe_i (func_tout_oe_i),
    .pad_oe_o       (pad_oe_o),
    .irq_o          (irq_o),
    .irq_oe_o       (irq_oe_o),
    .tout_o         (tout_o),
    .tout_oe_o      (tout_oe_o)
  );

endmodule

// File: rtl/tree_test_ctrl_chk.sv
module tree_test_ctrl_chk
  import tree_test_pkg::*;
#(
  parameter int C1_LEN = 8,
  parameter int C2_LEN = 6,
  parameter int NUM_OE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        test_mode_i,
  input logic              test_clk_i,
  input logic              test_din_i,
  input logic              test_run_i,
  input logic              seed1_i,
  input logic              seed2_i,
  input logic [C1_LEN-1:0] chain1_pad_i,
  input logic [C2_LEN-1:0] chain2_pad_i,
  input logic [NUM_OE-1:0] func_oe_i,
  input logic              func_irq_i,
  input logic [NUM_OE-1:0] pad_oe_o,
  input logic              irq_o,
  input logic              irq_oe_o,
  input logic              tout_o,
  input logic              tout_oe_o,
  input tree_mode_e        mode_q
);

  logic run_q = 1'b0;

  always_ff @(posedge clk) run_q <= !rst;

  AST_NAND_ENTRY: assert property (@(posedge clk)
    (rst && test_mode_i == 3'b111 && !test_clk_i && !test_din_i && test_run_i)
      |=> mode_q == MODE_NAND); // R1

  AST_XNOR_ENTRY: assert property (@(posedge clk)
    (rst && test_mode_i == 3'b111 && !test_clk_i && test_din_i && !test_run_i)
      |=> mode_q == MODE_XNOR); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    run_q |-> $stable(mode_q)); // R4

  AST_XNOR_PARITY: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_XNOR |->
      (tout_o == (seed2_i ^ $countones(~chain2_pad_i) % 2 == 1)) &&
      (irq_o  == (seed1_i ^ $countones(~chain1_pad_i) % 2 == 1))); // R6

  AST_TREE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    mode_q != MODE_NORMAL |-> pad_oe_o == '0 && irq_oe_o && tout_oe_o); // R8

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_NORMAL |-> pad_oe_o == func_oe_i && irq_o == func_irq_i); // R9

endmodule

bind tree_test_ctrl tree_test_ctrl_chk #(
  .C1_LEN (C1_LEN),
  .C2_LEN (C2_LEN),
  .NUM_OE (NUM_OE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .test_mode_i  (test_mode_i),
  .test_clk_i   (test_clk_i),
  .test_din_i   (test_din_i),
  .test_run_i   (test_run_i),
  .seed1_i      (seed1_i),
  .seed2_i      (seed2_i),
  .chain1_pad_i (chain1_pad_i),
  .chain2_pad_i (chain2_pad_i),
  .func_oe_i    (func_oe_i),
  .func_irq_i   (func_irq_i),
  .pad_oe_o     (pad_oe_o),
  .irq_o        (irq_o),
  .irq_oe_o     (irq_oe_o),
  .tout_o       (tout_o),
  .tout_oe_o    (tout_oe_o),
  .mode_q       (mode_q)
);

// File: tb/tree_test_ctrl_bench.sv
module tree_test_ctrl_bench;

  localparam int C1 = 8;
  localparam int C2 = 6;
  localparam int NOE = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b0;
  logic [2:0]     tmode = 3'b000;
  logic           tclk = 1'b0, tdin = 1'b0, trun = 1'b0;
  logic           seed1 = 1'b0, seed2 = 1'b0;
  logic [C1-1:0]  c1pad = '0;
  logic [C2-1:0]  c2pad = '0;
  logic [NOE-1:0] foe = '0;
  logic           firq = 1'b0, firq_oe = 1'b0, ftout = 1'b0, ftout_oe = 1'b0;
  logic [NOE-1:0] pad_oe;
  logic           irq, irq_oe, tout, tout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tree_test_ctrl #(.C1_LEN(C1), .C2_LEN(C2), .NUM_OE(NOE)) u_tree_test_ctrl (
    .clk(clk), .rst(rst), .test_mode_i(tmode), .test_clk_i(tclk),
    .test_din_i(tdin), .test_run_i(trun), .seed1_i(seed1), .seed2_i(seed2),
    .chain1_pad_i(c1pad), .chain2_pad_i(c2pad), .func_oe_i(foe),
    .func_irq_i(firq), .func_irq_oe_i(firq_oe), .func_tout_i(ftout),
    .func_tout_oe_i(ftout_oe), .pad_oe_o(pad_oe), .irq_o(irq),
    .irq_oe_o(irq_oe), .tout_o(tout), .tout_oe_o(tout_oe)
  );

  function automatic logic model1(input bit nand_m, input logic sd, input logic [C1-1:0] p);
    logic s = sd;
    for (int i = 0; i < C1; i++) s = nand_m ? ~(s & p[i]) : ~(s ^ p[i]);
    return s;
  endfunction

  function automatic logic model2(input bit nand_m, input logic sd, input logic [C2-1:0] p);
    logic s = sd;
    for (int i = 0; i < C2; i++) s = nand_m ? ~(s & p[i]) : ~(s ^ p[i]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic c, input logic d, input logic r);
    @(negedge clk);
    tmode = m; tclk = c; tdin = d; trun = r; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Expects tree mode with enables forced (R8) and chain outputs per model.
  task automatic chk_tree(input string req, input bit nand_m);
    #1;
    chk("R8 pad_oe", {16'd0, pad_oe}, 32'd0);
    chk("R8 irq_oe/tout_oe", {30'd0, irq_oe, tout_oe}, 32'd3);
    chk(req, {30'd0, irq, tout},
        {30'd0, model1(nand_m, seed1, c1pad), model2(nand_m, seed2, c2pad)});
  endtask

  task automatic chk_normal(input string req);
    foe = 16'hA5C3; firq = 1'b1; firq_oe = 1'b0; ftout = 1'b0; ftout_oe = 1'b1;
    #1;
    chk({req, " R9 oe"}, {16'd0, pad_oe}, {16'd0, foe});
    chk({req, " R9 outs"}, {28'd0, irq, irq_oe, tout, tout_oe}, 32'b1001);
    foe = 16'h3C5A; firq = 1'b0; firq_oe = 1'b1; ftout = 1'b1; ftout_oe = 1'b0;
    #1;
    chk({req, " R9 oe2"}, {16'd0, pad_oe}, {16'd0, foe});
    chk({req, " R9 outs2"}, {28'd0, irq, irq_oe, tout, tout_oe}, 32'b0110);
  endtask

  task automatic t_reset_normal();
    do_reset(3'b000, 1'b0, 1'b0, 1'b0);
    chk_normal("R3 reset default");
  endtask

  task automatic t_nand();
    foe = '1; firq_oe = 1'b0; ftout_oe = 1'b0;
    do_reset(3'b111, 1'b0, 1'b0, 1'b1);
    seed1 = 1'b1; seed2 = 1'b1; c1pad = '1; c2pad = '1;
    chk_tree("R1 R5 nand all ones", 1'b1);
    for (int k = 0; k < 20; k++) begin
      seed1 = $urandom; seed2 = $urandom; c1pad = $urandom; c2pad = $urandom;
      chk_tree("R5 nand pattern", 1'b1);
    end
    seed1 = 1'b1; seed2 = 1'b1;
    for (int k = 0; k < C1; k++) begin
      c1pad = ~(C1'(1) << k);
      c2pad = ~(C2'(1) << (k % C2));
      chk_tree("R7 walking zero", 1'b1);
    end
    c1pad = ~C1'(1);
    #1;
    chk("R7 far end zero", {31'd0, irq}, 32'd0);
    c1pad = ~(C1'(1) << (C1 - 1));
    #1;
    chk("R7 near end zero", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_xnor();
    do_reset(3'b111, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      seed1 = $urandom; seed2 = $urandom; c1pad = $urandom; c2pad = $urandom;
      chk_tree("R2 R6 xnor pattern", 1'b0);
    end
    seed1 = 1'b0; seed2 = 1'b1; c1pad = '1; c2pad = '0;
    #1;
    chk("R6 xnor all ones/zeros", {30'd0, irq, tout}, {30'd0, 1'b0, 1'b1});
  endtask

  task automatic t_hold();
    do_reset(3'b111, 1'b0, 1'b0, 1'b1);
    tmode = 3'b111; tclk = 1'b0; tdin = 1'b1; trun = 1'b0;
    repeat (3) @(negedge clk);
    seed1 = 1'b1; c1pad = '1; seed2 = 1'b0; c2pad = '1;
    chk_tree("R4 held nand vs xnor pins", 1'b1);
    tmode = 3'b000;
    repeat (3) @(negedge clk);
    chk_tree("R4 held nand vs normal pins", 1'b1);
    do_reset(3'b010, 1'b0, 1'b0, 1'b1);
    tmode = 3'b111; tdin = 1'b0; trun = 1'b1;
    repeat (3) @(negedge clk);
    chk_normal("R4 held normal");
  endtask

  task automatic t_other();
    do_reset(3'b111, 1'b1, 1'b0, 1'b1);
    chk_normal("R3 tclk high");
    do_reset(3'b110, 1'b0, 1'b0, 1'b1);
    chk_normal("R3 bus 110");
    do_reset(3'b011, 1'b0, 1'b1, 1'b0);
    chk_normal("R3 bus 011");
    do_reset(3'b111, 1'b0, 1'b1, 1'b1);
    chk_normal("R3 din=run=1");
    do_reset(3'b111, 1'b0, 1'b0, 1'b0);
    chk_normal("R3 din=run=0");
  endtask

  task automatic t_comb();
    do_reset(3'b111, 1'b0, 1'b0, 1'b1);
    c1pad = '1; c2pad = '1;
    @(posedge clk);
    #1;
    seed1 = 1'b0; seed2 = 1'b0;
    #1;
    chk("R10 seed low", {30'd0, irq, tout},
        {30'd0, model1(1'b1, 1'b0, c1pad), model2(1'b1, 1'b0, c2pad)});
    seed1 = 1'b1; seed2 = 1'b1;
    #1;
    chk("R10 seed high", {30'd0, irq, tout},
        {30'd0, model1(1'b1, 1'b1, c1pad), model2(1'b1, 1'b1, c2pad)});
    c1pad[C1-1] = 1'b0;
    #1;
    chk("R10 pad change", {31'd0, irq}, {31'd0, model1(1'b1, 1'b1, c1pad)});
  endtask

  initial begin
    t_reset_normal();
    t_nand();
    t_xnor();
    t_hold();
    t_other();
    t_comb();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule